// File: doc/BRIEF.md
# Serial audio link frame receiver

This block is the codec-side deserializer for the controller-to-codec serial stream of a PC audio link. It runs on the falling edge of the bit clock. A low-to-high transition of the frame sync line starts a frame, and the data line is shifted in MSB first. Each frame is a 16-bit tag slot followed by twelve 20-bit slots, 256 bit clocks in all.

The tag's top bit marks the whole frame valid. The next four bits mark slots 1 to 4 valid one by one. From slots 1 and 2 the receiver builds a register-access command: a read/write flag, a 7-bit register address and 16 bits of write data. From slots 3 and 4 it takes the left and right playback samples and cuts each to 18 bits. Each result comes with a one-cycle valid strobe. The register file, rate conversion and bit clock generation belong to other blocks.

Top module: `slink_rx_top`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, all three strobes are low and all data outputs are zero until a frame produces a result.
- R2: A frame starts only on a falling bit-clock edge where `sync_in` is sampled high after being sampled low. Data before the first such edge is ignored. A new rise during a frame drops the partial frame and restarts bit counting from tag bit 15.
- R3: When tag bit 15 (the first bit of the frame) is 0, the frame produces no command and no samples, whatever the other tag bits hold.
- R4: A write command (`cmd_rd`=0) is issued when tag bits 15, 14 and 13 are all 1 and slot 1 bit 19 is 0. `cmd_addr` is slot 1 bits 18:12 and `cmd_wdata` is slot 2 bits 19:4. Slot 1 bits 11:0 and slot 2 bits 3:0 have no effect.
- R5: A write (slot 1 bit 19 = 0) with tag bit 13 clear produces no command, even when tag bits 15 and 14 are set.
- R6: A read command (`cmd_rd`=1, `cmd_wdata`=0, address from slot 1 bits 18:12) is issued when tag bits 15 and 14 are 1 and slot 1 bit 19 is 1, whatever tag bit 13 is.
- R7: When tag bits 15 and 12 are 1, `left_valid` pulses and `left_data` carries slot 3 bits 19:2. Otherwise there is no left strobe.
- R8: When tag bits 15 and 11 are 1, `right_valid` pulses and `right_data` carries slot 4 bits 19:2. Otherwise there is no right strobe.
- R9: The contents of slots 5 to 12 and of tag bits 10:0 have no effect on any output.
- R10: Each strobe is high for exactly one bit-clock cycle and at most one strobe is high at a time. Each strobe rises on the falling edge that samples the last bit of its slot: slot 2 for the command, slot 3 for left, slot 4 for right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync; a rise marks a new frame |
| sdata_in | input | 1 | Serial data from the controller, MSB first |
| cmd_valid | output | 1 | One-cycle strobe: register command available |
| cmd_rd | output | 1 | 1 = read, 0 = write |
| cmd_addr | output | 7 | Register address |
| cmd_wdata | output | 16 | Write data (zero for reads) |
| left_valid | output | 1 | One-cycle strobe: left sample available |
| left_data | output | 18 | Left playback sample |
| right_valid | output | 1 | One-cycle strobe: right sample available |
| right_data | output | 18 | Right playback sample |

## Verification
Frames are sent with tag patterns that separate the gating terms: all slots valid, frame-valid clear with every slot bit set, a read with the slot 2 bit clear, and a write with the slot 2 bit clear. Together these show whether each output checks the frame bit, its own slot bit, and (for commands) the read/write flag. A frame with every ignored bit set to one (low slot bits, the low tag bits, slots 5 to 12) shows that the field slicing is exact. A stream with sync held low and a frame cut short by an early sync rise show that frame alignment comes only from the sync edge. Every expected item carries the bit-clock cycle it must appear in, so a one-cycle shift in any strobe is caught.

// File: rtl/slink_rx_pkg.sv
package slink_rx_pkg;
  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int NUM_SLOTS = 12;
  localparam int SMP_BITS  = 18;
  localparam int ADDR_BITS = 7;
  localparam int WDAT_BITS = 16;

  // length in bits of slot idx (slot 0 is the tag)
  function automatic int slot_len(input int idx, input int tag_w, input int slot_w);
    return (idx == 0) ? tag_w : slot_w;
  endfunction
endpackage

// File: rtl/slink_rx_framer.sv
module slink_rx_framer
  import slink_rx_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = NUM_SLOTS,
  localparam int SIW    = $clog2(N_SLOTS + 1),
  localparam int PW     = $clog2((SLOT_W > TAG_W) ? SLOT_W : TAG_W)
) (
  input  logic           bclk,
  input  logic           rst_n,
  input  logic           sync_in,
  output logic           sync_rise,
  output logic           frame_active,
  output logic           bit_take,
  output logic           last_bit,
  output logic [SIW-1:0] slot_idx,
  output logic [PW-1:0]  bit_pos
);
  logic sync_q;

  always_comb begin
    sync_rise = sync_in & ~sync_q;
    bit_take  = frame_active & ~sync_rise;
    last_bit  = bit_take &
                (bit_pos == PW'(slot_len(int'(slot_idx), TAG_W, SLOT_W) - 1));
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q       <= 1'b0;
      frame_active <= 1'b0;
      slot_idx     <= '0;
      bit_pos      <= '0;
    end else begin
      sync_q <= sync_in;
      if (sync_rise) begin
        frame_active <= 1'b1;
        slot_idx     <= '0;
        bit_pos      <= '0;
      end else if (last_bit) begin
        bit_pos <= '0;
        if (slot_idx == SIW'(N_SLOTS)) frame_active <= 1'b0;
        else                           slot_idx     <= slot_idx + 1'b1;
      end else if (bit_take) begin
        bit_pos <= bit_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slink_rx_shift.sv
module slink_rx_shift #(
  parameter int W = 20
) (
  input  logic         bclk,
  input  logic         rst_n,
  input  logic         bit_take,
  input  logic         sdata_in,
  output logic [W-1:0] word
);
  logic [W-2:0] sh_q;

  // the word including the bit being sampled on this edge
  assign word = {sh_q, sdata_in};

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (bit_take) sh_q <= word[W-2:0];
  end
endmodule

// File: rtl/slink_rx_decode.sv
module slink_rx_decode
  import slink_rx_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = NUM_SLOTS,
  parameter int SMP_W   = SMP_BITS,
  parameter int ADDR_W  = ADDR_BITS,
  parameter int WD_W    = WDAT_BITS,
  localparam int SIW    = $clog2(N_SLOTS + 1)
) (
  input  logic                       bclk,
  input  logic                       rst_n,
  input  logic                       last_bit,
  input  logic [SIW-1:0]             slot_idx,
  input  logic [SLOT_W-1:0]          word,
  output logic                       cmd_valid,
  output logic                       cmd_rd,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic [WD_W-1:0]            cmd_wdata,
  output logic [1:0]                 smp_valid,
  output logic [1:0][SMP_W-1:0]      smp_data
);
  localparam int SLOT_CMD  = 1;
  localparam int SLOT_WDAT = 2;
  localparam int SLOT_SMP0 = 3;

  logic [TAG_W-1:0]  tag_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic slot_ok(input logic [TAG_W-1:0] t, input int idx);
    return t[TAG_W-1] & t[TAG_W-1-idx];
  endfunction
  function automatic logic [ADDR_W-1:0] f_addr(input logic [SLOT_W-1:0] w);
    return w[SLOT_W-2 -: ADDR_W];
  endfunction
  function automatic logic [WD_W-1:0] f_wdata(input logic [SLOT_W-1:0] w);
    return w[SLOT_W-1 -: WD_W];
  endfunction
  function automatic logic [SMP_W-1:0] f_sample(input logic [SLOT_W-1:0] w);
    return w[SLOT_W-1 -: SMP_W];
  endfunction

  logic at_tag, at_cmd, at_wdat, cmd_fire;
  always_comb begin
    at_tag   = last_bit && (slot_idx == '0);
    at_cmd   = last_bit && (slot_idx == SIW'(SLOT_CMD));
    at_wdat  = last_bit && (slot_idx == SIW'(SLOT_WDAT));
    cmd_fire = at_wdat && slot_ok(tag_q, SLOT_CMD) &&
               (rd_q || tag_q[TAG_W-1-SLOT_WDAT]);
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= '0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_rd    <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (at_tag) tag_q <= word[TAG_W-1:0];
      if (at_cmd) begin
        rd_q   <= word[SLOT_W-1];
        addr_q <= f_addr(word);
      end
      if (cmd_fire) begin
        cmd_valid <= 1'b1;
        cmd_rd    <= rd_q;
        cmd_addr  <= addr_q;
        cmd_wdata <= rd_q ? '0 : f_wdata(word);
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam int SL = SLOT_SMP0 + c;
    logic             v_q;
    logic [SMP_W-1:0] d_q;
    always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= 1'b0;
        if (last_bit && (slot_idx == SIW'(SL)) && slot_ok(tag_q, SL)) begin
          v_q <= 1'b1;
          d_q <= f_sample(word);
        end
      end
    end
    assign smp_valid[c] = v_q;
    assign smp_data[c]  = d_q;
  end
endmodule

// File: rtl/slink_rx_top.sv
module slink_rx_top
  import slink_rx_pkg::*;
#(
  parameter int TAG_W   = TAG_BITS,
  parameter int SLOT_W  = SLOT_BITS,
  parameter int N_SLOTS = NUM_SLOTS,
  parameter int SMP_W   = SMP_BITS,
  parameter int ADDR_W  = ADDR_BITS,
  parameter int WD_W    = WDAT_BITS,
  localparam int SIW    = $clog2(N_SLOTS + 1),
  localparam int PW     = $clog2((SLOT_W > TAG_W) ? SLOT_W : TAG_W)
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              sdata_in,
  output logic              cmd_valid,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WD_W-1:0]   cmd_wdata,
  output logic              left_valid,
  output logic [SMP_W-1:0]  left_data,
  output logic              right_valid,
  output logic [SMP_W-1:0]  right_data
);
  logic              sync_rise, frame_active, bit_take, last_bit;
  logic [SIW-1:0]    slot_idx;
  logic [PW-1:0]     bit_pos;
  logic [SLOT_W-1:0] word;
  logic [1:0]               smp_valid;
  logic [1:0][SMP_W-1:0]    smp_data;

  slink_rx_framer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_framer (
    .bclk(bclk), .rst_n(rst_n), .sync_in(sync_in),
    .sync_rise(sync_rise), .frame_active(frame_active), .bit_take(bit_take),
    .last_bit(last_bit), .slot_idx(slot_idx), .bit_pos(bit_pos)
  );

  slink_rx_shift #(.W(SLOT_W)) u_shift (
    .bclk(bclk), .rst_n(rst_n), .bit_take(bit_take), .sdata_in(sdata_in), .word(word)
  );

  slink_rx_decode #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS),
    .SMP_W(SMP_W), .ADDR_W(ADDR_W), .WD_W(WD_W)
  ) u_decode (
    .bclk(bclk), .rst_n(rst_n), .last_bit(last_bit), .slot_idx(slot_idx), .word(word),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  assign left_valid  = smp_valid[0];
  assign left_data   = smp_data[0];
  assign right_valid = smp_valid[1];
  assign right_data  = smp_data[1];
endmodule

// File: rtl/slink_rx_chk.sv
module slink_rx_chk #(
  parameter int SIW   = 4,
  parameter int PW    = 5,
  parameter int WD_W  = 16
) (
  input logic            bclk,
  input logic            rst_n,
  input logic            sync_rise,
  input logic            frame_active,
  input logic            last_bit,
  input logic [SIW-1:0]  slot_idx,
  input logic [PW-1:0]   bit_pos,
  input logic            cmd_valid,
  input logic            cmd_rd,
  input logic [WD_W-1:0] cmd_wdata,
  input logic            left_valid,
  input logic            right_valid
);
  // R2: a sync rise restarts counting at the first tag bit
  p_restart_r2: assert property (@(negedge bclk) disable iff (!rst_n)
    sync_rise |=> (frame_active && slot_idx == '0 && bit_pos == '0));

  // R2: nothing comes out while no frame is being received
  p_idle_quiet_r2: assert property (@(negedge bclk) disable iff (!rst_n)
    !frame_active |=> !(cmd_valid || left_valid || right_valid));

  // R6: reads carry no write data
  p_read_zero_r6: assert property (@(negedge bclk) disable iff (!rst_n)
    (cmd_valid && cmd_rd) |-> (cmd_wdata == '0));

  // R7: left strobe follows the end of slot 3
  p_left_slot_r7: assert property (@(negedge bclk) disable iff (!rst_n)
    left_valid |-> $past(last_bit && slot_idx == SIW'(3)));

  // R8: right strobe follows the end of slot 4
  p_right_slot_r8: assert property (@(negedge bclk) disable iff (!rst_n)
    right_valid |-> $past(last_bit && slot_idx == SIW'(4)));

  // R10: command strobe follows the end of slot 2
  p_cmd_slot_r10: assert property (@(negedge bclk) disable iff (!rst_n)
    cmd_valid |-> $past(last_bit && slot_idx == SIW'(2)));

  // R10: single-cycle strobes, never two at once
  p_cmd_pulse_r10: assert property (@(negedge bclk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_left_pulse_r10: assert property (@(negedge bclk) disable iff (!rst_n)
    left_valid |=> !left_valid);
  p_right_pulse_r10: assert property (@(negedge bclk) disable iff (!rst_n)
    right_valid |=> !right_valid);
  p_one_strobe_r10: assert property (@(negedge bclk) disable iff (!rst_n)
    $onehot0({cmd_valid, left_valid, right_valid}));
endmodule

bind slink_rx_top slink_rx_chk #(.SIW(SIW), .PW(PW), .WD_W(WD_W)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .sync_rise(sync_rise), .frame_active(frame_active),
  .last_bit(last_bit), .slot_idx(slot_idx), .bit_pos(bit_pos),
  .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
  .left_valid(left_valid), .right_valid(right_valid)
);

// File: tb/slink_rx_top_tb_top.sv
module slink_rx_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic sdata_in = 1'b0;
  logic        cmd_valid, cmd_rd, left_valid, right_valid;
  logic [6:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic [17:0] left_data, right_data;

  always #4 clk = ~clk;  // 125 MHz

  slink_rx_top dut_i (
    .bclk(clk), .rst_n(rst_n), .sync_in(sync_in), .sdata_in(sdata_in),
    .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .left_valid(left_valid), .left_data(left_data),
    .right_valid(right_valid), .right_data(right_data)
  );

  typedef struct {
    int          at;
    int          kind;   // 0 command, 1 left, 2 right
    logic [23:0] pay;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  int   n_strobes = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input int kind, input logic [23:0] got);
    exp_t e;
    n_checks++;
    if (q.size() == 0) begin
      n_fail++;
      $display("FAIL R10 unexpected strobe kind %0d at cycle %0d got %h exp none", kind, cyc, got);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.pay != got || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s kind %0d/%0d cycle %0d/%0d got %h exp %h",
                 e.req, kind, e.kind, cyc, e.at, got, e.pay);
      end
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(posedge clk) begin
    if (rst_n && !done) begin
      if (cmd_valid)   begin n_strobes++; compare(0, {cmd_rd, cmd_addr, cmd_wdata}); end
      if (left_valid)  begin n_strobes++; compare(1, {6'd0, left_data}); end
      if (right_valid) begin n_strobes++; compare(2, {6'd0, right_data}); end
    end
  end

  task automatic push(input int at, input int kind, input logic [23:0] pay, input string req);
    exp_t e;
    e.at = at; e.kind = kind; e.pay = pay; e.req = req;
    q.push_back(e);
  endtask

  // driver: sends one frame (or its first nbits) and queues what must come out
  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                            input logic [19:0] fill, input int nbits, input string req);
    logic [255:0] fr;
    int start;
    fr = {tag, s1, s2, s3, s4, {8{fill}}};
    @(posedge clk);
    start = cyc;
    sync_in  <= 1'b1;
    sdata_in <= 1'b0;
    if (nbits == 256 && tag[15]) begin
      // R4 / R6: command on a valid slot 1, write also needs slot 2
      if (tag[14] && s1[19])
        push(start + 57, 0, {1'b1, s1[18:12], 16'h0000}, {req, " R6 read"});
      else if (tag[14] && tag[13])
        push(start + 57, 0, {1'b0, s1[18:12], s2[19:4]}, {req, " R4 write"});
      if (tag[12]) push(start + 77, 1, {6'd0, s3[19:2]}, {req, " R7 left"});
      if (tag[11]) push(start + 97, 2, {6'd0, s4[19:2]}, {req, " R8 right"});
    end
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk);
      sync_in  <= (i < 15);
      sdata_in <= fr[255-i];
    end
  endtask

  task automatic check_drained(input int seen_before, input int exp_new, input string req);
    n_checks++;
    if (q.size() != 0 || (n_strobes - seen_before) != exp_new) begin
      n_fail++;
      $display("FAIL %s strobes got %0d exp %0d, pending %0d",
               req, n_strobes - seen_before, exp_new, q.size());
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0;
    // R1: reset state
    repeat (3) @(posedge clk);
    n_checks++;
    if ({cmd_valid, left_valid, right_valid} != 3'b000 || cmd_addr != 0 || cmd_wdata != 0 ||
        left_data != 0 || right_data != 0 || cmd_rd != 0) begin
      n_fail++;
      $display("FAIL R1 in reset got %b exp 000", {cmd_valid, left_valid, right_valid});
    end
    @(posedge clk);
    rst_n <= 1'b1;
    repeat (2) @(posedge clk);
    n_checks++;
    if ({cmd_valid, left_valid, right_valid} != 3'b000 || left_data != 0 || right_data != 0) begin
      n_fail++;
      $display("FAIL R1 after reset got %b exp 000", {cmd_valid, left_valid, right_valid});
    end

    // R2: bits with no sync rise are ignored
    s0 = n_strobes;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      sdata_in <= (i % 3 != 0);
    end
    check_drained(s0, 0, "R2 no sync");

    // R4 R7 R8: everything valid, write
    s0 = n_strobes;
    send_frame(16'hF800, {1'b0, 7'h15, 12'h000}, {16'hBEEF, 4'h0},
               20'hA5A5C, 20'h3C3C0, 20'h00000, 256, "F1");
    check_drained(s0, 3, "R4 F1");

    // R6: read with slot 2 tag clear, slot 2 holds junk; left only
    s0 = n_strobes;
    send_frame(16'hD000, {1'b1, 7'h2A, 12'h000}, 20'hABCDE,
               20'h12345, 20'hFFFFF, 20'h00000, 256, "F2");
    check_drained(s0, 2, "R6 F2");

    // R3: frame-valid clear with all slot bits set
    s0 = n_strobes;
    send_frame(16'h7800, {1'b0, 7'h7F, 12'h000}, 20'h55550,
               20'hFFFFC, 20'h0000C, 20'h00000, 256, "F3");
    check_drained(s0, 0, "R3 F3");

    // R5: write with slot 2 tag clear; right only
    s0 = n_strobes;
    send_frame(16'hC800, {1'b0, 7'h01, 12'h000}, {16'h1234, 4'h0},
               20'h11111, 20'h80004, 20'h00000, 256, "F4");
    check_drained(s0, 1, "R5 F4");

    // R9 (and R4 field slicing): every ignored bit set to one
    s0 = n_strobes;
    send_frame(16'hFFFF, {1'b0, 7'h44, 12'hFFF}, {16'h0F0F, 4'hF},
               20'h0000F, 20'h7FFFF, 20'hFFFFF, 256, "F5 R9");
    check_drained(s0, 3, "R9 F5");

    // R2: partial frame cut by an early sync rise, then a full frame
    s0 = n_strobes;
    send_frame(16'hF800, {1'b0, 7'h33, 12'h000}, {16'hDEAD, 4'h0},
               20'hFFFFF, 20'hFFFFF, 20'h00000, 30, "F6a");
    send_frame(16'hF800, {1'b1, 7'h0C, 12'h000}, 20'h00000,
               20'h96960, 20'h69694, 20'h00000, 256, "F6b R2");
    check_drained(s0, 3, "R2 resync");

    // R10: a read back to back after a write
    s0 = n_strobes;
    send_frame(16'hE000, {1'b0, 7'h26, 12'h000}, {16'h8000, 4'h0},
               20'h0, 20'h0, 20'h00000, 256, "F7 R10");
    send_frame(16'hC000, {1'b1, 7'h7E, 12'h000}, 20'h0,
               20'h0, 20'h0, 20'h00000, 256, "F8 R10");
    check_drained(s0, 2, "R10 F7/F8");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule